// File: doc/BRIEF.md
# Block-Granular Security Filter

This block sits between a bus requester and a memory port and decides, for every transfer, whether its security attribute is allowed to reach the block of memory it addresses. The protected window is split into equal blocks whose size is a power of two. A bitmap holds one bit per block, packed 32 to a register word. A bit of 1 opens the block to non-secure transfers. A bit of 0 reserves the block for secure transfers. The address is first made relative to the window base and then shifted up by a fixed offset, so the window can start part-way into the bitmap. The shifted address is cut into a block number, and the block number is cut into a bitmap word and a bit within it.

Permitted transfers pass straight to the memory port. A denied transfer never reaches memory. The block answers it locally one cycle after acceptance, with either an error or a silent read-as-zero/write-dropped reply, chosen by a control bit. The denied transfer also latches a sticky fault flag that can raise an interrupt. A gating handshake lets software quiesce the port. Once the request bit is set, no new transfers are taken. The acknowledge bit rises when nothing is outstanding. While gated, arriving transfers either stall or receive an immediate error. At most one transfer is outstanding at any time.

Software reaches the controls and the bitmap through a simple write-strobe register port with combinational read data. The register offsets are: control 0x00, block size code 0x01, interrupt enable 0x02, fault status 0x03, fault clear 0x04, and bitmap word w at 0x80 + w.

Top module: `blkprot_checker`

## Requirements
- R1: A block spans 2^(BLK_CFG+5) bytes, and the block size code register (offset 0x01) reads BLK_CFG. For an address A, let n = A - RANGE_BASE + RANGE_OFFSET. The block number is b = n >> (BLK_CFG+5), and the governing bit is bit b mod 32 of bitmap word b / 32.
- R2: A non-secure transfer to a block whose bit is 1 is forwarded to the memory port. A secure transfer is forwarded whatever the bit. A non-secure transfer to a block whose bit is 0 is a fault and is not forwarded.
- R3: With control bit 4 set, a faulting transfer gets a response with the error flag set, in the cycle after it is accepted.
- R4: With control bit 4 clear, a faulting read returns data 0 with no error, and a faulting write gets a no-error response and never reaches the memory port.
- R5: An address below RANGE_BASE, or one whose n is at or beyond NUM_WORDS*32 blocks, is treated as a secure block.
- R6: A fault sets status bit 0 (offset 0x03), and the bit stays set until 1 is written to bit 0 of offset 0x04. If a fault and a clear land in the same cycle, the status stays set. irq equals status bit 0 AND enable bit 0 (offset 0x02).
- R7: Setting control bit 6 blocks new transfers at once. Control bit 7 (acknowledge) reads 1 only after no transfer is outstanding.
- R8: While acknowledged with control bit 16 clear, up_ready stays low and nothing is forwarded. With bit 16 set, each arriving transfer gets an error response, is not forwarded and does not set the fault status.
- R9: After bit 6 is cleared, bit 7 still reads 1 for one cycle and reads 0 from the next cycle on. Control bit 23 reads 1 when GATE_EN is nonzero.
- R10: At most one transfer is outstanding. up_ready is low from acceptance until its response has been delivered.
- R11: Bitmap words read back what was written at offset 0x80 + w, and all of them reset to 0 (every block secure).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Fault interrupt |
| up_valid | input | 1 | Requester transfer valid |
| up_ready | output | 1 | Transfer accepted when high with up_valid |
| up_addr | input | ADDR_W | Transfer byte address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_nonsec | input | 1 | 1 = non-secure transfer |
| up_wdata | input | DATA_W | Write data |
| up_resp_valid | output | 1 | Response valid |
| up_resp_err | output | 1 | Response carries an error |
| up_resp_rdata | output | DATA_W | Read data |
| dn_valid | output | 1 | Forwarded transfer valid |
| dn_ready | input | 1 | Memory port accepts |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded direction |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_resp_valid | input | 1 | Memory response valid |
| dn_resp_err | input | 1 | Memory response error |
| dn_resp_rdata | input | DATA_W | Memory read data |

## Verification
The bench targets several edges that would catch a wrong design:
- The first and last blocks of the window and the addresses just outside it. A design that dropped the range offset, or misplaced the word/bit split, would read a neighbouring bit and flip the permit decision.
- A faulting write in the silent mode. A design that forwarded it would show an extra transfer at the memory port.
- A fault and a status clear in the same cycle. A design that let the clear win would lose the interrupt.
- A gate request issued while a slow memory response is pending. A design that acknowledged early would report quiescence with a transfer still in flight.
- The release window. A design that dropped acknowledge in the same cycle, or held it longer, would show the wrong bit 7 one cycle after the write.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;

   localparam int unsigned LUT_W = 32;
   localparam int unsigned REG_W = 32;

   // control register bit positions
   localparam int unsigned BIT_FAULT_ERR = 4;
   localparam int unsigned BIT_GATE_REQ  = 6;
   localparam int unsigned BIT_GATE_ACK  = 7;
   localparam int unsigned BIT_GATE_ERR  = 16;
   localparam int unsigned BIT_GATE_HAS  = 23;

   typedef enum logic [2:0] {
      SEL_CTRL    = 3'd0,
      SEL_BLKCFG  = 3'd1,
      SEL_INTEN   = 3'd2,
      SEL_INTSTAT = 3'd3,
      SEL_INTCLR  = 3'd4
   } reg_sel_e;

   typedef struct packed {
      logic fault_err;
      logic gate_req;
      logic gate_err;
   } ctrl_t;

endpackage

// File: rtl/blkprot_lookup.sv
module blkprot_lookup
   import blkprot_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter int                BLK_CFG      = 0,
   parameter int                NUM_WORDS    = 4,
   parameter logic [ADDR_W-1:0] RANGE_BASE   = '0,
   parameter logic [ADDR_W-1:0] RANGE_OFFSET = '0,
   localparam int               WIDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] rw_idx,
   input  logic [LUT_W-1:0]  wr_data,
   output logic [LUT_W-1:0]  rd_data,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_in_range,
   output logic              q_ns_bit
);

   localparam int              BLK_SH = BLK_CFG + 5;
   localparam int              BIDX_W = WIDX_W + 5;
   localparam longint unsigned SPAN_L = longint'(NUM_WORDS) * 32 * (longint'(1) << BLK_SH);
   localparam logic [ADDR_W:0] SPAN   = (ADDR_W+1)'(SPAN_L);

   if (NUM_WORDS < 1) begin : g_bad_words
      $error("NUM_WORDS must be at least 1");
   end
   if (SPAN_L > (longint'(1) << ADDR_W)) begin : g_bad_span
      $error("protected span exceeds the address space");
   end
   if (longint'(RANGE_OFFSET) >= SPAN_L) begin : g_bad_offset
      $error("RANGE_OFFSET must lie inside the bitmap span");
   end

   logic [LUT_W-1:0] words_q [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words_q[w] <= '0;
         else if (wr_en && rw_idx == WIDX_W'(w))
            words_q[w] <= wr_data;
      end
   end

   // address normalisation and index split
   logic [ADDR_W:0]   rel;
   logic [ADDR_W:0]   norm;
   logic [BIDX_W-1:0] blk;
   logic [WIDX_W-1:0] word;
   logic [4:0]        bitpos;
   logic [LUT_W-1:0]  q_word_val;

   assign rel        = {1'b0, q_addr} - {1'b0, RANGE_BASE};
   assign norm       = {1'b0, rel[ADDR_W-1:0]} + {1'b0, RANGE_OFFSET};
   assign q_in_range = !rel[ADDR_W] && (norm < SPAN);
   assign blk        = norm[BLK_SH +: BIDX_W];
   assign word       = blk[BIDX_W-1:5];
   assign bitpos     = blk[4:0];

   always_comb begin
      q_word_val = '0;
      rd_data    = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (word == WIDX_W'(w))   q_word_val = words_q[w];
         if (rw_idx == WIDX_W'(w)) rd_data    = words_q[w];
      end
   end

   assign q_ns_bit = q_in_range && q_word_val[bitpos];

   assert_word_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      q_in_range |-> (int'(word) < NUM_WORDS))
      else $error("in-range address selected a missing bitmap word");

endmodule

// File: rtl/blkprot_gate.sv
module blkprot_gate #(
   parameter int GATE_EN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic busy,
   output logic ack
);

   if (GATE_EN != 0) begin : g_gate
      logic ack_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ack_q <= 1'b0;
         else        ack_q <= req & (ack_q | ~busy);
      end
      assign ack = ack_q;

      assert_ack_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack_q) |-> !$past(busy))
         else $error("gate acknowledged with a transfer outstanding");

      assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!req && ack_q) |=> !ack_q)
         else $error("gate acknowledge held after release");
   end else begin : g_nogate
      assign ack = 1'b0;
   end

endmodule

// File: rtl/blkprot_regs.sv
module blkprot_regs
   import blkprot_pkg::*;
#(
   parameter int  GATE_EN   = 1,
   parameter int  BLK_CFG   = 0,
   parameter int  NUM_WORDS = 4,
   parameter int  REG_AW    = 8,
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [LUT_W-1:0]  lut_rdata,
   output logic              lut_we,
   output logic [WIDX_W-1:0] lut_idx,
   input  logic              gate_ack,
   input  logic              fault_evt,
   output ctrl_t             ctrl,
   output logic              irq
);

   localparam logic GATE_ON = (GATE_EN != 0);

   if (REG_AW < 5) begin : g_bad_aw
      $error("REG_AW must be at least 5");
   end
   if (longint'(NUM_WORDS) > (longint'(1) << (REG_AW - 1))) begin : g_bad_map
      $error("bitmap does not fit the register window");
   end

   logic [REG_AW-2:0] lut_off;
   logic              is_lut, is_reg, clr_wr;
   reg_sel_e          sel;
   ctrl_t             ctrl_q;
   logic              en_q, stat_q;

   assign lut_off = reg_addr[REG_AW-2:0];
   assign is_lut  = reg_addr[REG_AW-1] && (lut_off < (REG_AW-1)'(NUM_WORDS));
   assign is_reg  = !reg_addr[REG_AW-1] && (reg_addr[REG_AW-2:3] == '0);
   assign sel     = reg_sel_e'(reg_addr[2:0]);
   assign lut_idx = lut_off[WIDX_W-1:0];
   assign lut_we  = reg_we && is_lut;
   assign clr_wr  = reg_we && is_reg && (sel == SEL_INTCLR) && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         if (reg_we && is_reg && sel == SEL_CTRL) begin
            ctrl_q.fault_err <= reg_wdata[BIT_FAULT_ERR];
            ctrl_q.gate_req  <= reg_wdata[BIT_GATE_REQ] & GATE_ON;
            ctrl_q.gate_err  <= reg_wdata[BIT_GATE_ERR] & GATE_ON;
         end
         if (reg_we && is_reg && sel == SEL_INTEN)
            en_q <= reg_wdata[0];
         if (fault_evt)   stat_q <= 1'b1;
         else if (clr_wr) stat_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (is_lut) begin
         reg_rdata = lut_rdata;
      end else if (is_reg) begin
         case (sel)
            SEL_CTRL: begin
               reg_rdata[BIT_FAULT_ERR] = ctrl_q.fault_err;
               reg_rdata[BIT_GATE_REQ]  = ctrl_q.gate_req;
               reg_rdata[BIT_GATE_ACK]  = gate_ack;
               reg_rdata[BIT_GATE_ERR]  = ctrl_q.gate_err;
               reg_rdata[BIT_GATE_HAS]  = GATE_ON;
            end
            SEL_BLKCFG:  reg_rdata    = REG_W'(BLK_CFG);
            SEL_INTEN:   reg_rdata[0] = en_q;
            SEL_INTSTAT: reg_rdata[0] = stat_q;
            default:     reg_rdata    = '0;
         endcase
      end
   end

   assign ctrl = ctrl_q;
   assign irq  = stat_q & en_q;

   assert_stat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !clr_wr) |=> stat_q)
      else $error("fault status dropped without a clear");

   assert_stat_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> $past(fault_evt))
      else $error("fault status rose without a fault");

endmodule

// File: rtl/blkprot_checker.sv
module blkprot_checker
   import blkprot_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter int                DATA_W       = 32,
   parameter int                BLK_CFG      = 0,
   parameter int                NUM_WORDS    = 4,
   parameter logic [ADDR_W-1:0] RANGE_BASE   = 32'h1000_0000,
   parameter logic [ADDR_W-1:0] RANGE_OFFSET = 32'h0000_0040,
   parameter int                GATE_EN      = 1,
   parameter int                REG_AW       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_write,
   input  logic              up_nonsec,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_resp_valid,
   output logic              up_resp_err,
   output logic [DATA_W-1:0] up_resp_rdata,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_write,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_resp_valid,
   input  logic              dn_resp_err,
   input  logic [DATA_W-1:0] dn_resp_rdata
);

   localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

   ctrl_t             ctrl;
   logic              gate_ack, fault_evt, lut_we;
   logic [WIDX_W-1:0] lut_idx;
   logic [LUT_W-1:0]  lut_rdata;
   logic              q_in_range, q_ns_bit;
   logic              busy_q, loc_rsp_q, loc_err_q;
   logic              gate_blk, violation, accept, local_take;

   blkprot_lookup #(
      .ADDR_W(ADDR_W), .BLK_CFG(BLK_CFG), .NUM_WORDS(NUM_WORDS),
      .RANGE_BASE(RANGE_BASE), .RANGE_OFFSET(RANGE_OFFSET)
   ) i_lookup (
      .clk(clk), .rst_n(rst_n),
      .wr_en(lut_we), .rw_idx(lut_idx), .wr_data(reg_wdata), .rd_data(lut_rdata),
      .q_addr(up_addr), .q_in_range(q_in_range), .q_ns_bit(q_ns_bit)
   );

   blkprot_regs #(
      .GATE_EN(GATE_EN), .BLK_CFG(BLK_CFG), .NUM_WORDS(NUM_WORDS), .REG_AW(REG_AW)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .lut_rdata(lut_rdata), .lut_we(lut_we), .lut_idx(lut_idx),
      .gate_ack(gate_ack), .fault_evt(fault_evt), .ctrl(ctrl), .irq(irq)
   );

   blkprot_gate #(.GATE_EN(GATE_EN)) i_gate (
      .clk(clk), .rst_n(rst_n), .req(ctrl.gate_req), .busy(busy_q), .ack(gate_ack)
   );

   assign gate_blk  = ctrl.gate_req | gate_ack;
   assign violation = up_nonsec & ~(q_in_range & q_ns_bit);

   always_comb begin
      up_ready = 1'b0;
      dn_valid = 1'b0;
      if (!busy_q) begin
         if (gate_blk) begin
            up_ready = gate_ack & ctrl.gate_err;
         end else if (violation) begin
            up_ready = 1'b1;
         end else begin
            up_ready = dn_ready;
            dn_valid = up_valid;
         end
      end
   end

   assign accept     = up_valid & up_ready;
   assign local_take = accept & (gate_blk | violation);
   assign fault_evt  = accept & ~gate_blk & violation;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         loc_rsp_q <= 1'b0;
         loc_err_q <= 1'b0;
      end else begin
         if (accept)             busy_q <= 1'b1;
         else if (up_resp_valid) busy_q <= 1'b0;
         loc_rsp_q <= local_take;
         if (local_take) loc_err_q <= gate_blk | ctrl.fault_err;
      end
   end

   assign dn_addr       = up_addr;
   assign dn_write      = up_write;
   assign dn_wdata      = up_wdata;
   assign up_resp_valid = loc_rsp_q | dn_resp_valid;
   assign up_resp_err   = loc_rsp_q ? loc_err_q : dn_resp_err;
   assign up_resp_rdata = loc_rsp_q ? '0 : dn_resp_rdata;

   assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (!dn_valid && !up_ready))
      else $error("second transfer issued while one is outstanding");

   assert_resp_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      up_resp_valid |-> busy_q)
      else $error("response with nothing outstanding");

   assert_fault_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && violation && !gate_blk && ctrl.fault_err) |=> (up_resp_valid && up_resp_err))
      else $error("fault in error mode did not return an error");

   assert_fault_raz_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && violation && !gate_blk && !ctrl.fault_err)
         |=> (up_resp_valid && !up_resp_err && up_resp_rdata == '0))
      else $error("silent fault returned data or an error");

   assert_gated_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_ack && !ctrl.gate_err) |-> (!up_ready && !dn_valid))
      else $error("transfer taken while gated in stall mode");

endmodule

// File: tb/test_blkprot_checker.sv
module test_blkprot_checker;
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [31:0] BASE  = 32'h1000_0000;
   localparam logic [31:0] OFF   = 32'h0000_0040;
   localparam longint      SPANB = 4 * 32 * 32;
   localparam logic [31:0] MAGIC = 32'hC3C3_0000;
   localparam logic [31:0] WMIX  = 32'h1234_5678;
   localparam logic [7:0]  A_CTRL = 8'h00, A_BCFG = 8'h01, A_IEN = 8'h02,
                           A_ISTAT = 8'h03, A_ICLR = 8'h04, A_LUT = 8'h80;

   // {addr, write, nonsec, error-mode}
   localparam logic [34:0] VEC [14] = '{
      {32'h1000_0000, 1'b0, 1'b1, 1'b0},
      {32'h1000_0200, 1'b0, 1'b1, 1'b0},
      {32'h1000_0200, 1'b1, 1'b1, 1'b0},
      {32'h1000_0200, 1'b0, 1'b1, 1'b1},
      {32'h1000_0200, 1'b0, 1'b0, 1'b1},
      {32'h1000_03C0, 1'b0, 1'b1, 1'b1},
      {32'h1000_0440, 1'b1, 1'b1, 1'b1},
      {32'h1000_07BF, 1'b0, 1'b1, 1'b0},
      {32'h1000_0FBF, 1'b0, 1'b1, 1'b1},
      {32'h1000_0FC0, 1'b0, 1'b1, 1'b1},
      {32'h0FFF_FFFC, 1'b0, 1'b1, 1'b0},
      {32'h1000_0FC0, 1'b0, 1'b0, 1'b0},
      {32'h1000_0BC0, 1'b1, 1'b1, 1'b0},
      {32'h1000_0BE0, 1'b1, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        up_valid = 1'b0, up_write = 1'b0, up_nonsec = 1'b0;
   logic [31:0] up_addr = '0, up_wdata = '0;
   logic        up_ready, up_resp_valid, up_resp_err;
   logic [31:0] up_resp_rdata;
   logic        dn_valid, dn_write;
   logic        dn_ready = 1'b1;
   logic [31:0] dn_addr, dn_wdata;
   logic        dn_resp_valid = 1'b0;
   logic [31:0] dn_resp_rdata = '0;
   logic        dn_resp_err;

   int          checks = 0, fails = 0;
   int          dn_delay = 0, dn_count = 0, cnt = 0;
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0, dn_last_wdata = '0;
   logic [31:0] lut_m [4];

   assign dn_resp_err = 1'b0;

   always #2.5 clk = ~clk;

   blkprot_checker i_blkprot_checker (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq),
      .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_write(up_write),
      .up_nonsec(up_nonsec), .up_wdata(up_wdata),
      .up_resp_valid(up_resp_valid), .up_resp_err(up_resp_err), .up_resp_rdata(up_resp_rdata),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write),
      .dn_wdata(dn_wdata), .dn_resp_valid(dn_resp_valid), .dn_resp_err(dn_resp_err),
      .dn_resp_rdata(dn_resp_rdata)
   );

   // memory port model with programmable response delay
   always @(posedge clk) begin
      dn_resp_valid <= 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            dn_resp_valid <= 1'b1;
            dn_resp_rdata <= pend_addr ^ MAGIC;
            pend <= 1'b0;
         end else cnt <= cnt - 1;
      end else if (dn_valid && dn_ready) begin
         dn_count <= dn_count + 1;
         if (dn_write) dn_last_wdata <= dn_wdata;
         if (dn_delay == 0) begin
            dn_resp_valid <= 1'b1;
            dn_resp_rdata <= dn_addr ^ MAGIC;
         end else begin
            pend      <= 1'b1;
            cnt       <= dn_delay - 1;
            pend_addr <= dn_addr;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic xfer(input logic [31:0] a, input logic wr, input logic ns,
                       output logic err, output logic [31:0] rd, output logic fwd);
      int c0;
      int guard;
      @(negedge clk);
      c0 = dn_count;
      up_valid = 1'b1; up_addr = a; up_write = wr; up_nonsec = ns; up_wdata = a ^ WMIX;
      #1;
      guard = 0;
      while (!up_ready && guard < 50) begin @(negedge clk); #1; guard++; end
      @(negedge clk);
      up_valid = 1'b0;
      guard = 0;
      while (!up_resp_valid && guard < 50) begin @(negedge clk); guard++; end
      err = up_resp_err;
      rd  = up_resp_rdata;
      @(negedge clk);
      fwd = (dn_count != c0);
   endtask

   function automatic logic model_fault(input logic [31:0] a, input logic ns);
      longint rel, blk;
      logic   nsbit;
      rel = longint'(a) - longint'(BASE);
      if (rel < 0 || rel + longint'(OFF) >= SPANB) nsbit = 1'b0;
      else begin
         blk   = (rel + longint'(OFF)) >> 5;
         nsbit = lut_m[int'(blk / 32)][int'(blk % 32)];
      end
      return ns && !nsbit;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rv, rd;
      logic        err, fwd;
      int          guard;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd_reg(A_CTRL, rv);  chk("R9 reset ctrl, gate present", rv, 32'h0080_0000);
      rd_reg(A_ISTAT, rv); chk("R6 reset status", rv, 32'h0);
      chk("R6 reset irq", {31'h0, irq}, 32'h0);
      rd_reg(A_LUT + 8'd2, rv); chk("R11 reset bitmap secure", rv, 32'h0);
      rd_reg(A_BCFG, rv); chk("R1 block size code", rv, 32'h0);

      lut_m[0] = 32'h0000_FFFF; lut_m[1] = 32'hF0F0_F0F0;
      lut_m[2] = 32'hFFFF_FFFF; lut_m[3] = 32'h8000_0001;
      for (int w = 0; w < 4; w++) wr_reg(A_LUT + 8'(w), lut_m[w]);
      rd_reg(A_LUT + 8'd1, rv); chk("R11 bitmap readback", rv, 32'hF0F0_F0F0);

      // vector table: R1 index split, R2 permit, R3/R4 fault replies, R5 range edges
      for (int v = 0; v < 14; v++) begin
         logic [31:0] a;
         logic        wr, ns, em, flt;
         string       tag;
         {a, wr, ns, em} = VEC[v];
         wr_reg(A_CTRL, {27'h0, em, 4'h0});
         flt = model_fault(a, ns);
         xfer(a, wr, ns, err, rd, fwd);
         if (flt) tag = em ? "R3 R1 fault error" : "R4 R1 fault silent";
         else     tag = "R2 R1 R5 permitted";
         chk(tag, {30'h0, err, fwd}, {30'h0, flt & em, !flt});
         if (!flt && wr)       chk("R2 forwarded write data", dn_last_wdata, a ^ WMIX);
         else if (!flt && !wr) chk("R2 forwarded read data", rd, a ^ MAGIC);
         else if (!wr && !em)  chk("R4 read as zero", rd, 32'h0);
         else                  chk("R3 R4 fault data", rd, 32'h0);
      end

      // interrupt path
      rd_reg(A_ISTAT, rv); chk("R6 status sticky after faults", rv, 32'h1);
      chk("R6 irq masked", {31'h0, irq}, 32'h0);
      wr_reg(A_IEN, 32'h1);
      #1; chk("R6 irq enabled", {31'h0, irq}, 32'h1);
      wr_reg(A_ICLR, 32'h1);
      rd_reg(A_ISTAT, rv); chk("R6 status cleared", rv, 32'h0);
      chk("R6 irq after clear", {31'h0, irq}, 32'h0);

      // fault and clear in the same cycle
      @(negedge clk);
      reg_we = 1'b1; reg_addr = A_ICLR; reg_wdata = 32'h1;
      up_valid = 1'b1; up_addr = 32'h1000_0200; up_write = 1'b0; up_nonsec = 1'b1;
      #1; chk("R2 fault accepted locally", {31'h0, up_ready}, 32'h1);
      @(negedge clk);
      reg_we = 1'b0; up_valid = 1'b0;
      rd_reg(A_ISTAT, rv); chk("R6 fault beats clear", rv, 32'h1);
      chk("R6 irq on simultaneous fault", {31'h0, irq}, 32'h1);
      @(negedge clk);
      wr_reg(A_ICLR, 32'h1);

      // gate request while a slow transfer is outstanding
      dn_delay = 4;
      @(negedge clk);
      up_valid = 1'b1; up_addr = BASE; up_write = 1'b0; up_nonsec = 1'b1;
      #1; chk("R2 slow transfer accepted", {31'h0, up_ready}, 32'h1);
      @(negedge clk);
      up_valid = 1'b0;
      #1; chk("R10 ready low while outstanding", {31'h0, up_ready}, 32'h0);
      wr_reg(A_CTRL, 32'h0000_0040);
      rd_reg(A_CTRL, rv); chk("R7 no ack while outstanding", {31'h0, rv[7]}, 32'h0);
      guard = 0;
      while (!up_resp_valid && guard < 50) begin @(negedge clk); guard++; end
      rd_reg(A_CTRL, rv); chk("R7 no ack in response cycle", {31'h0, rv[7]}, 32'h0);
      dn_delay = 0;
      guard = 0;
      rd_reg(A_CTRL, rv);
      while (!rv[7] && guard < 6) begin @(negedge clk); rd_reg(A_CTRL, rv); guard++; end
      chk("R7 ack after idle", {31'h0, rv[7]}, 32'h1);

      // stall mode
      begin
         int c0;
         logic seen_ready;
         seen_ready = 1'b0;
         c0 = dn_count;
         @(negedge clk);
         up_valid = 1'b1; up_addr = BASE; up_nonsec = 1'b0;
         for (int k = 0; k < 4; k++) begin
            #1; if (up_ready) seen_ready = 1'b1;
            @(negedge clk);
         end
         up_valid = 1'b0;
         chk("R8 stall holds ready low", {31'h0, seen_ready}, 32'h0);
         chk("R8 nothing forwarded while stalled", dn_count, c0);
      end

      // gated error mode
      wr_reg(A_CTRL, 32'h0001_0040);
      xfer(BASE, 1'b0, 1'b1, err, rd, fwd);
      chk("R8 gated error reply", {30'h0, err, fwd}, 32'h2);
      rd_reg(A_ISTAT, rv); chk("R8 gated reply raises no fault", rv, 32'h0);

      // release
      wr_reg(A_CTRL, 32'h0);
      rd_reg(A_CTRL, rv); chk("R9 ack held one cycle", {31'h0, rv[7]}, 32'h1);
      @(negedge clk);
      rd_reg(A_CTRL, rv); chk("R9 ack dropped", {31'h0, rv[7]}, 32'h0);
      xfer(BASE, 1'b0, 1'b1, err, rd, fwd);
      chk("R2 traffic resumes after release", rd, BASE ^ MAGIC);

      finish_run();
   end

endmodule